// File: doc/BRIEF.md
# Exception Entry Stacking Sequencer

This block performs the processor state changes that follow acceptance of an interrupt. Arbitration happens elsewhere. When `accept_i` is seen in the idle state, the block captures the interrupted program counter, its instruction length class, the status word, the system stack pointer, the table base, the interrupt number and the interrupt level. It then steps through a fixed sequence:

1. Lower the stack pointer by one word and push the status word.
2. Lower the stack pointer again and push the return address.
3. Load the new interrupt level mask and clear the stack-select flag.
4. Read the handler address from the vector table and load it into the program counter.

Memory traffic goes through one request/acknowledge port. Register changes leave the block as write strobes with their values. On the program counter load cycle the block samples `accept_i` again. If a new request is pending there, it starts a fresh entry at once, before any handler instruction has run. The handler address is then used as that entry's return address.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is held and on the first cycle after its release, `busy_o`, `mem_req_o`, `ssp_we_o`, `ilm_we_o`, `sflag_clr_o` and `pc_we_o` are all low.
- R2: `accept_i` high in idle starts a sequence. `busy_o` goes high in the next cycle and stays high through the `pc_we_o` cycle. It is low in the cycle after that unless a re-entry starts.
- R3: `ssp_we_o` pulses twice per sequence, one cycle each. The first pulse carries the captured stack pointer minus 4 and the second carries it minus 8.
- R4: The first memory access is a write (`mem_we_o`=1) of the status word to the address of the first decrement. The second is a write of the return address to the address of the second decrement.
- R5: The return address is the captured program counter plus 2, 4 or 6 for length class 0, 1 or 2. Class 3 gives plus 2.
- R6: In the cycle after the second write is acknowledged, `ilm_we_o` and `sflag_clr_o` are high together for one cycle, and `ilm_o` equals the captured level.
- R7: The third access is a read (`mem_we_o`=0) at table base + 0x3FC − 4 × interrupt number. In the cycle after its acknowledge, `pc_we_o` is high and `pc_o` equals the word read.
- R8: A request holds its address, data and direction unchanged until `mem_ack_i` is seen. An acknowledge with no request pending has no effect.
- R9: If `accept_i` is high in the `pc_we_o` cycle, a new sequence begins with `busy_o` still high. Its stack continues from the last pushed address, and its return address is the handler address just loaded.
- R10: `accept_i` pulses that arrive while busy, other than in the `pc_we_o` cycle, are ignored. The interrupt inputs captured at acceptance stay in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| accept_i | input | 1 | Interrupt accepted; sampled in idle and in the PC load cycle |
| int_num_i | input | 8 | Interrupt number of the accepted request |
| int_lvl_i | input | 5 | Interrupt level of the accepted request |
| pc_i | input | 32 | Address of the interrupted instruction |
| len_cls_i | input | 2 | Instruction length class (0: +2, 1: +4, 2: +6, 3: +2) |
| ps_i | input | 32 | Status word to be pushed |
| ssp_i | input | 32 | System stack pointer at acceptance |
| tbr_i | input | 32 | Vector table base |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| busy_o | output | 1 | Sequence in progress |
| ssp_we_o | output | 1 | Stack pointer update strobe |
| ssp_o | output | 32 | New stack pointer value |
| ilm_we_o | output | 1 | Level mask update strobe |
| ilm_o | output | 5 | New level mask value |
| sflag_clr_o | output | 1 | Clear stack-select flag |
| pc_we_o | output | 1 | Program counter load strobe |
| pc_o | output | 32 | Handler address |

## Verification
The bench varies the acknowledge latency from zero to several cycles. A design that advanced on request instead of on acknowledge, or that let its address or data drift while waiting, would push to the wrong word. It covers all four length classes, including the class 3 fallback, and interrupt numbers 0 and 255 at both ends of the vector table, where a sign or scaling error in the offset shows up. Re-entry in the PC load cycle is checked for an uninterrupted busy flag, a stack that continues downward, and a return address equal to the handler address. Stray accept pulses and stray acknowledges arrive at moments when a careless design would restart or skip a step.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_DEC1, S_PUSH_PS, S_DEC2, S_PUSH_RA, S_SET_ILM, S_FETCH, S_LOAD_PC
  } seq_state_t;

  // Byte increment from the interrupted instruction to the next one.
  function automatic logic [2:0] len_step(input logic [1:0] cls);
    case (cls)
      2'd1:    len_step = 3'd4;
      2'd2:    len_step = 3'd6;
      default: len_step = 3'd2;
    endcase
  endfunction
endpackage

// File: rtl/exc_ra_calc.sv
module exc_ra_calc #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] pc_i,
  input  logic [1:0]    cls_i,
  output logic [AW-1:0] ra_o
);
  assign ra_o = pc_i + AW'(exc_pkg::len_step(cls_i));

  always_comb begin
    a_r5_ra_even: assert (cls_i === 2'bx || ra_o[0] == pc_i[0]);
  end
endmodule

// File: rtl/exc_vec_addr.sv
module exc_vec_addr #(
  parameter int AW    = 32,
  parameter int NUM_W = 8
) (
  input  logic [AW-1:0]    base_i,
  input  logic [NUM_W-1:0] num_i,
  output logic [AW-1:0]    addr_o
);
  localparam logic [AW-1:0] TOP_OFF = AW'((64'd1 << (NUM_W + 2)) - 64'd4);

  // Word entries descending from the top of the table.
  function automatic logic [AW-1:0] vec_off(input logic [NUM_W-1:0] n);
    vec_off = TOP_OFF - (AW'(n) << 2);
  endfunction

  assign addr_o = base_i + vec_off(num_i);
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int AW    = 32,
  parameter int NUM_W = 8,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic [NUM_W-1:0] int_num_i,
  input  logic [LVL_W-1:0] int_lvl_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [1:0]       len_cls_i,
  input  logic [AW-1:0]    ps_i,
  input  logic [AW-1:0]    ssp_i,
  input  logic [AW-1:0]    tbr_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [AW-1:0]    mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [AW-1:0]    mem_rdata_i,
  output logic             busy_o,
  output logic             ssp_we_o,
  output logic [AW-1:0]    ssp_o,
  output logic             ilm_we_o,
  output logic [LVL_W-1:0] ilm_o,
  output logic             sflag_clr_o,
  output logic             pc_we_o,
  output logic [AW-1:0]    pc_o
);
  import exc_pkg::*;

  localparam logic [AW-1:0] WORD = AW'(4);

  seq_state_t       st_q;
  logic [AW-1:0]    ssp_q, ps_q, ra_q, tbr_q, vec_q;
  logic [NUM_W-1:0] num_q;
  logic [LVL_W-1:0] lvl_q;
  logic [AW-1:0]    ra_calc, vec_addr;

  // Named internal events for the checks.
  logic start_ev, reentry_ev, xfer_done;

  exc_ra_calc #(.AW(AW)) u_ra (
    .pc_i (pc_i),
    .cls_i(len_cls_i),
    .ra_o (ra_calc)
  );

  exc_vec_addr #(.AW(AW), .NUM_W(NUM_W)) u_vec (
    .base_i(tbr_q),
    .num_i (num_q),
    .addr_o(vec_addr)
  );

  assign start_ev   = (st_q == S_IDLE) && accept_i;
  assign reentry_ev = (st_q == S_LOAD_PC) && accept_i;
  assign xfer_done  = mem_req_o && mem_ack_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      ssp_q <= '0;
      ps_q  <= '0;
      ra_q  <= '0;
      tbr_q <= '0;
      vec_q <= '0;
      num_q <= '0;
      lvl_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (accept_i) begin
          ssp_q <= ssp_i;
          ps_q  <= ps_i;
          ra_q  <= ra_calc;
          tbr_q <= tbr_i;
          num_q <= int_num_i;
          lvl_q <= int_lvl_i;
          st_q  <= S_DEC1;
        end
        S_DEC1: begin
          ssp_q <= ssp_q - WORD;
          st_q  <= S_PUSH_PS;
        end
        S_PUSH_PS: if (mem_ack_i) st_q <= S_DEC2;
        S_DEC2: begin
          ssp_q <= ssp_q - WORD;
          st_q  <= S_PUSH_RA;
        end
        S_PUSH_RA: if (mem_ack_i) st_q <= S_SET_ILM;
        S_SET_ILM: st_q <= S_FETCH;
        S_FETCH: if (mem_ack_i) begin
          vec_q <= mem_rdata_i;
          st_q  <= S_LOAD_PC;
        end
        S_LOAD_PC: if (accept_i) begin
          // Nested entry before the handler's first instruction.
          ps_q  <= ps_i;
          ra_q  <= vec_q;
          tbr_q <= tbr_i;
          num_q <= int_num_i;
          lvl_q <= int_lvl_i;
          st_q  <= S_DEC1;
        end else begin
          st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = (st_q == S_PUSH_PS) || (st_q == S_PUSH_RA) || (st_q == S_FETCH);
    mem_we_o    = (st_q == S_PUSH_PS) || (st_q == S_PUSH_RA);
    mem_addr_o  = (st_q == S_FETCH) ? vec_addr : ssp_q;
    mem_wdata_o = (st_q == S_PUSH_RA) ? ra_q : ps_q;
    busy_o      = (st_q != S_IDLE);
    ssp_we_o    = (st_q == S_DEC1) || (st_q == S_DEC2);
    ssp_o       = ssp_q - WORD;
    ilm_we_o    = (st_q == S_SET_ILM);
    sflag_clr_o = (st_q == S_SET_ILM);
    ilm_o       = lvl_q;
    pc_we_o     = (st_q == S_LOAD_PC);
    pc_o        = vec_q;
  end

  // R8: request fields frozen until acknowledged
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
                                && $stable(mem_wdata_o) && $stable(mem_we_o));

  // R2: no activity at the ports while idle
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o && !ssp_we_o && !ilm_we_o && !pc_we_o);

  // R3: stack decrements never back to back
  a_r3_single_dec: assert property (@(posedge clk) disable iff (!rst_n)
    ssp_we_o |=> !ssp_we_o);

  // R3: a write lands where the previous decrement pointed
  a_r3_write_at_new_sp: assert property (@(posedge clk) disable iff (!rst_n)
    ssp_we_o |=> mem_addr_o == $past(ssp_o));

  // R6: only one kind of state change per cycle
  a_r6_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ssp_we_o, mem_req_o, ilm_we_o, pc_we_o}));

  // R7: PC load follows an acknowledged read
  a_r7_pc_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && !mem_we_o |=> pc_we_o && pc_o == $past(mem_rdata_i));

  // R9: re-entry keeps busy high
  a_r9_reentry_busy: assert property (@(posedge clk) disable iff (!rst_n)
    reentry_ev |=> busy_o && ssp_we_o);

  // R2: a start always leads to a decrement
  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> busy_o && ssp_we_o);
endmodule

// File: tb/sim_exc_entry_seq.sv
module sim_exc_entry_seq;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        accept_i = 0;
  logic [7:0]  int_num_i = 0;
  logic [4:0]  int_lvl_i = 0;
  logic [31:0] pc_i = 0, ps_i = 0, ssp_i = 0, tbr_i = 0, mem_rdata_i = 0;
  logic [1:0]  len_cls_i = 0;
  logic        mem_ack_i = 0;
  logic        mem_req_o, mem_we_o, busy_o, ssp_we_o, ilm_we_o, sflag_clr_o, pc_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o, ssp_o, pc_o;
  logic [4:0]  ilm_o;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  exc_entry_seq u0 (.*);

  typedef struct packed {
    logic [31:0] pc; logic [1:0] cls; logic [31:0] ssp; logic [31:0] tbr;
    logic [31:0] ps; logic [31:0] vec; logic [7:0] num; logic [4:0] lvl; logic [2:0] lat;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VT [NV] = '{
    '{32'h0000_1000, 2'd0, 32'h0000_8000, 32'h000F_FC00, 32'hA5A5_0001, 32'h0001_2340, 8'd0,   5'd3,  3'd0},
    '{32'h0000_2002, 2'd1, 32'h0000_7F00, 32'h0010_0000, 32'h1234_5678, 32'h0002_0000, 8'd255, 5'd17, 3'd1},
    '{32'h0000_3004, 2'd2, 32'h0000_4010, 32'h0000_0400, 32'hDEAD_BEEF, 32'h0003_0010, 8'd3,   5'd30, 3'd3},
    '{32'h0000_400E, 2'd3, 32'h0000_0100, 32'h2000_0000, 32'h0F0F_0F0F, 32'h0004_4444, 8'd128, 5'd0,  3'd2},
    '{32'hFFFF_FFFE, 2'd2, 32'h1000_0004, 32'h0000_0000, 32'h8000_0000, 32'h0005_5550, 8'd1,   5'd15, 3'd5}
  };

  function automatic logic [31:0] step_of(input logic [1:0] c);
    return (c == 2'd2) ? 32'd6 : (c == 2'd1) ? 32'd4 : 32'd2;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input vec_t v);
    pc_i = v.pc; len_cls_i = v.cls; ssp_i = v.ssp; tbr_i = v.tbr;
    ps_i = v.ps; int_num_i = v.num; int_lvl_i = v.lvl;
  endtask

  // Wait for a request, confirm it holds, then acknowledge.
  task automatic serve(input int lat, input logic [31:0] rd, input string req,
                       input logic exp_we, input logic [31:0] exp_addr,
                       input logic [31:0] exp_wd);
    int n = 0;
    while (!mem_req_o && n < 20) begin @(posedge clk); @(negedge clk); n++; end
    chk(req, {31'd0, mem_req_o}, 32'd1);
    chk(req, {31'd0, mem_we_o}, {31'd0, exp_we});
    chk(req, mem_addr_o, exp_addr);
    if (exp_we) chk(req, mem_wdata_o, exp_wd);
    for (int i = 0; i < lat; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R8 hold", {mem_req_o, mem_we_o, mem_addr_o[29:0]}, {1'b1, exp_we, exp_addr[29:0]});
    end
    mem_ack_i = 1; mem_rdata_i = rd;
    @(posedge clk); @(negedge clk);
    mem_ack_i = 0; mem_rdata_i = 32'h0BAD_0BAD;
  endtask

  // Called at the negedge where accept is raised; returns at the PC load negedge.
  task automatic follow(input vec_t v, input logic [31:0] sp0, input logic [31:0] ra,
                        input logic noise);
    @(posedge clk); @(negedge clk);
    accept_i = noise;
    if (noise) int_num_i = 8'hAA;
    chk("R2 busy", {31'd0, busy_o}, 32'd1);
    chk("R3 dec1", {31'd0, ssp_we_o}, 32'd1);
    chk("R3 sp1", ssp_o, sp0 - 32'd4);
    @(posedge clk); @(negedge clk);
    accept_i = 0;
    serve(v.lat, 32'h0, "R4 ps push", 1'b1, sp0 - 32'd4, v.ps);
    chk("R3 dec2", {31'd0, ssp_we_o}, 32'd1);
    chk("R3 sp2", ssp_o, sp0 - 32'd8);
    @(posedge clk); @(negedge clk);
    serve(v.lat, 32'h0, "R5 ra push", 1'b1, sp0 - 32'd8, ra);
    chk("R6 ilm/s", {30'd0, ilm_we_o, sflag_clr_o}, 32'd3);
    chk("R6 level", {27'd0, ilm_o}, {27'd0, v.lvl});
    @(posedge clk); @(negedge clk);
    serve(v.lat, v.vec, "R7 vec read", 1'b0,
          v.tbr + 32'h3FC - ({24'd0, v.num} << 2), 32'h0);
    chk("R7 pc_we", {31'd0, pc_we_o}, 32'd1);
    chk("R7 pc", pc_o, v.vec);
    chk("R2 busy end", {31'd0, busy_o}, 32'd1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1 reset", {26'd0, busy_o, mem_req_o, ssp_we_o, ilm_we_o, sflag_clr_o, pc_we_o}, 32'd0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); @(negedge clk);
    chk("R1 after release", {26'd0, busy_o, mem_req_o, ssp_we_o, ilm_we_o, sflag_clr_o, pc_we_o}, 32'd0);

    // R8: stray acknowledge while idle
    mem_ack_i = 1;
    @(posedge clk); @(negedge clk);
    mem_ack_i = 0;
    chk("R8 stray ack", {30'd0, busy_o, mem_req_o}, 32'd0);

    // Table walk: R2..R7 with varied latency and length class
    for (int k = 0; k < NV; k++) begin
      load(VT[k]); accept_i = 1;
      follow(VT[k], VT[k].ssp, VT[k].pc + step_of(VT[k].cls), 1'b0);
      @(posedge clk); @(negedge clk);
      chk("R2 idle after", {31'd0, busy_o}, 32'd0);
    end

    // R10: stray accept mid-sequence is ignored
    load(VT[2]); accept_i = 1;
    follow(VT[2], VT[2].ssp, VT[2].pc + 32'd6, 1'b1);
    @(posedge clk); @(negedge clk);
    chk("R10 no restart", {31'd0, busy_o}, 32'd0);

    // R9: re-entry at the PC load cycle
    load(VT[0]); accept_i = 1;
    follow(VT[0], VT[0].ssp, VT[0].pc + 32'd2, 1'b0);
    load(VT[1]); ssp_i = 32'h7777_0000; accept_i = 1;
    follow(VT[1], VT[0].ssp - 32'd8, VT[0].vec, 1'b0);
    chk("R9 chained pc", pc_o, VT[1].vec);
    @(posedge clk); @(negedge clk);
    chk("R9 idle after chain", {31'd0, busy_o}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule